// File: doc/BRIEF.md
# Load-Use Stall Controller

This block sits in the decode stage of a five-stage in-order pipeline. Each cycle it looks at the instruction held in the execute-stage pipeline register and the instruction being decoded. If the execute-stage instruction is a load and its destination register is one of the decoder's two source registers, the loaded value cannot reach the decoder in time, even with forwarding. The block then stalls the front of the pipeline for one cycle and sends a bubble into execute in place of the decoded instruction.

A stall has two effects. The program-counter write enable and the fetch/decode register write enable are both deasserted, so the same instruction is fetched again and the same fields are decoded again. The control word passed into the execute-stage register is also forced to all zeros, which makes a do-nothing instruction. In the next cycle that bubble sits in execute, so its memory-read bit is clear and the stall ends by itself. The forwarding path then delivers the loaded value.

The decision is purely combinational. Its inputs are the execute-stage memory-read flag, the execute-stage destination field, the two decode source fields and the decoded control word. Register zero is hard-wired to zero, so a load that targets it never stalls.

Top module: `lu_stall_ctrl`

## Requirements
- R1: When `ex_mem_read` is 1, `ex_load_rt` is nonzero and `ex_load_rt` equals `id_src_a`, a stall is raised.
- R2: When `ex_mem_read` is 1, `ex_load_rt` is nonzero and `ex_load_rt` equals `id_src_b`, a stall is raised.
- R3: When `ex_mem_read` is 0, no stall is raised, whatever the register fields hold.
- R4: A load whose `ex_load_rt` is 0 never raises a stall, even when a source field is also 0.
- R5: During a stall `pc_we` and `ifid_we` are both 0. Otherwise both are 1.
- R6: During a stall all nine bits of `idex_ctrl` are 0.
- R7: Without a stall `idex_ctrl` equals `dec_ctrl` bit for bit.
- R8: In a pipeline where bit 5 of the control word is the memory-read flag that feeds back as `ex_mem_read`, a load followed at once by a dependent instruction gives exactly one bubble cycle. The dependent instruction is decoded for two cycles, and every later instruction reaches decode one cycle late.
- R9: A load whose destination matches neither source register raises no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_mem_read | input | 1 | Memory-read flag of the instruction in the execute-stage register |
| ex_load_rt | input | 5 | Destination register field of that instruction |
| id_src_a | input | 5 | First source register field of the instruction in decode |
| id_src_b | input | 5 | Second source register field of the instruction in decode |
| dec_ctrl | input | 9 | Control word produced by the main decoder |
| pc_we | output | 1 | Program-counter write enable, active high |
| ifid_we | output | 1 | Fetch/decode register write enable, active high |
| idex_ctrl | output | 9 | Control word to be written into the execute-stage register |

## Verification
The checker assumes only that all inputs are settled two-state values when it evaluates them. Because the block has no state, it places no constraint on how input values follow one another. The random stimulus draws register fields from a small set of indices, so matches, register-zero cases and loads with no match all occur often. The directed part closes the loop through a small pipeline model, so the memory-read flag in execute comes from the block's own previous output. This reproduces the real case where the bubble clears the load flag.

// File: rtl/lu_pkg.sv
package lu_pkg;
  // Default field widths for a 32-register, 9-control-bit datapath.
  localparam int REG_AW_DEF = 5;
  localparam int CTRL_W_DEF = 9;
  // Control word layout used by the surrounding datapath.
  localparam int CB_ALU_SRC   = 0;
  localparam int CB_ALU_OP0   = 1;
  localparam int CB_ALU_OP1   = 2;
  localparam int CB_DST_SEL   = 3;
  localparam int CB_BRANCH    = 4;
  localparam int CB_MEM_READ  = 5;
  localparam int CB_MEM_WRITE = 6;
  localparam int CB_REG_WRITE = 7;
  localparam int CB_MEM_TO_RG = 8;
endpackage

// File: rtl/lu_src_match.sv
module lu_src_match #(
  parameter int REG_AW     = lu_pkg::REG_AW_DEF,
  parameter bit ZERO_GUARD = 1'b1
) (
  input  logic              load_valid,
  input  logic [REG_AW-1:0] load_dst,
  input  logic [REG_AW-1:0] src,
  output logic              hit
);
  logic same;
  assign same = (load_dst == src);

  generate
    if (ZERO_GUARD) begin : g_guard
      // Register zero carries no real dependency.
      assign hit = load_valid && same && (load_dst != '0);
    end else begin : g_plain
      assign hit = load_valid && same;
    end
  endgenerate
endmodule

// File: rtl/lu_bubble_mux.sv
module lu_bubble_mux #(
  parameter int CTRL_W = lu_pkg::CTRL_W_DEF
) (
  input  logic              squash,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic [CTRL_W-1:0] ctrl_out
);
  always_comb begin
    ctrl_out = ctrl_in;
    if (squash) ctrl_out = '0;
  end
endmodule

// File: rtl/lu_stall_ctrl.sv
module lu_stall_ctrl #(
  parameter int REG_AW     = lu_pkg::REG_AW_DEF,
  parameter int CTRL_W     = lu_pkg::CTRL_W_DEF,
  parameter bit ZERO_GUARD = 1'b1
) (
  input  logic              ex_mem_read,
  input  logic [REG_AW-1:0] ex_load_rt,
  input  logic [REG_AW-1:0] id_src_a,
  input  logic [REG_AW-1:0] id_src_b,
  input  logic [CTRL_W-1:0] dec_ctrl,
  output logic              pc_we,
  output logic              ifid_we,
  output logic [CTRL_W-1:0] idex_ctrl
);
  localparam int NSRC = 2;

  logic [REG_AW-1:0] srcs [NSRC];
  logic [NSRC-1:0]   hits;
  logic              stall;

  assign srcs[0] = id_src_a;
  assign srcs[1] = id_src_b;

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_src
      lu_src_match #(.REG_AW(REG_AW), .ZERO_GUARD(ZERO_GUARD)) u_match (
        .load_valid (ex_mem_read),
        .load_dst   (ex_load_rt),
        .src        (srcs[gi]),
        .hit        (hits[gi])
      );
    end
  endgenerate

  assign stall   = |hits;
  assign pc_we   = ~stall;
  assign ifid_we = ~stall;

  lu_bubble_mux #(.CTRL_W(CTRL_W)) u_bubble (
    .squash   (stall),
    .ctrl_in  (dec_ctrl),
    .ctrl_out (idex_ctrl)
  );
endmodule

// File: rtl/lu_stall_ctrl_chk.sv
module lu_stall_ctrl_chk #(
  parameter int REG_AW = lu_pkg::REG_AW_DEF,
  parameter int CTRL_W = lu_pkg::CTRL_W_DEF
) (
  input logic              ex_mem_read,
  input logic [REG_AW-1:0] ex_load_rt,
  input logic [REG_AW-1:0] id_src_a,
  input logic [REG_AW-1:0] id_src_b,
  input logic [CTRL_W-1:0] dec_ctrl,
  input logic              pc_we,
  input logic              ifid_we,
  input logic [CTRL_W-1:0] idex_ctrl
);
  always_comb begin
    if (ex_mem_read && ex_load_rt != '0 && ex_load_rt == id_src_a)
      assert_stall_src_a_R1: assert (!pc_we);
    if (ex_mem_read && ex_load_rt != '0 && ex_load_rt == id_src_b)
      assert_stall_src_b_R2: assert (!ifid_we);
    if (!ex_mem_read)
      assert_no_load_no_stall_R3: assert (pc_we && ifid_we);
    if (ex_load_rt == '0)
      assert_zero_dst_no_stall_R4: assert (pc_we);
    assert_enables_agree_R5: assert (pc_we == ifid_we);
    if (!pc_we)
      assert_bubble_zero_R6: assert (idex_ctrl == '0);
    if (pc_we)
      assert_ctrl_passthru_R7: assert (idex_ctrl == dec_ctrl);
    if (ex_load_rt != id_src_a && ex_load_rt != id_src_b)
      assert_no_match_no_stall_R9: assert (ifid_we);
  end
endmodule

bind lu_stall_ctrl lu_stall_ctrl_chk #(.REG_AW(REG_AW), .CTRL_W(CTRL_W)) u_chk (
  .ex_mem_read (ex_mem_read),
  .ex_load_rt  (ex_load_rt),
  .id_src_a    (id_src_a),
  .id_src_b    (id_src_b),
  .dec_ctrl    (dec_ctrl),
  .pc_we       (pc_we),
  .ifid_we     (ifid_we),
  .idex_ctrl   (idex_ctrl)
);

// File: tb/tb_lu_stall_ctrl.sv
module tb_lu_stall_ctrl;
  localparam int AW = 5;
  localparam int CW = 9;
  localparam int MRB = 5;
  localparam logic [CW-1:0] C_LOAD = 9'b000100011;
  localparam logic [CW-1:0] C_ALU  = 9'b110000010;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          ex_mem_read;
  logic [AW-1:0] ex_load_rt, id_src_a, id_src_b;
  logic [CW-1:0] dec_ctrl, idex_ctrl;
  logic          pc_we, ifid_we;

  lu_stall_ctrl dut (
    .ex_mem_read(ex_mem_read), .ex_load_rt(ex_load_rt),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .dec_ctrl(dec_ctrl),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_ctrl(idex_ctrl)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  function automatic bit exp_stall(logic ld, logic [AW-1:0] d, logic [AW-1:0] a, logic [AW-1:0] b);
    return ld && (d != 0) && (d == a || d == b);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      report();
    end
  end

  // Drive one pattern and check all outputs against the requirements.
  task automatic apply(logic ld, logic [AW-1:0] d, logic [AW-1:0] a, logic [AW-1:0] b,
                       logic [CW-1:0] c, string req);
    bit s;
    @(negedge clk);
    ex_mem_read = ld; ex_load_rt = d; id_src_a = a; id_src_b = b; dec_ctrl = c;
    #1;
    s = exp_stall(ld, d, a, b);
    chk({req, " pc_we (R5)"}, pc_we, !s);
    chk({req, " ifid_we (R5)"}, ifid_we, !s);
    chk(s ? {req, " bubble (R6)"} : {req, " pass (R7)"}, idex_ctrl, s ? 0 : c);
  endtask

  // Small pipeline model: program of (ctrl, rs, rt) entries.
  logic          pipe_on = 0;
  logic [CW-1:0] p_ctrl [8];
  logic [AW-1:0] p_rs [8];
  logic [AW-1:0] p_rt [8];
  int            pc;
  int            ifid_idx;
  logic [CW-1:0] idex_q;
  logic [AW-1:0] idex_rt_q;

  always @(posedge clk) begin
    if (rst) begin
      pc <= 0; ifid_idx <= 7; idex_q <= '0; idex_rt_q <= '0;
    end else if (pipe_on) begin
      if (pc_we) pc <= (pc < 7) ? pc + 1 : 7;
      if (ifid_we) ifid_idx <= pc;
      idex_q <= idex_ctrl;
      idex_rt_q <= p_rt[ifid_idx];
    end
  end

  always_comb begin
    if (pipe_on) begin
      ex_mem_read = idex_q[MRB];
      ex_load_rt  = idex_rt_q;
      id_src_a    = p_rs[ifid_idx];
      id_src_b    = p_rt[ifid_idx];
      dec_ctrl    = p_ctrl[ifid_idx];
    end
  end

  task automatic load_prog(logic [AW-1:0] ld_dst, logic [AW-1:0] use_reg);
    for (int i = 0; i < 8; i++) begin p_ctrl[i] = '0; p_rs[i] = '0; p_rt[i] = '0; end
    p_ctrl[0] = C_LOAD; p_rs[0] = 5'd1; p_rt[0] = ld_dst;
    p_ctrl[1] = C_ALU;  p_rs[1] = use_reg; p_rt[1] = 5'd5;
    p_ctrl[2] = C_ALU;  p_rs[2] = 5'd6; p_rt[2] = use_reg;
    p_ctrl[3] = C_ALU;  p_rs[3] = 5'd4; p_rt[3] = use_reg;
  endtask

  // Run 10 cycles; return stall count, decode cycles of entry 1, first decode cycle of entry 3.
  task automatic run_prog(output int stalls, output int dec1, output int first3);
    stalls = 0; dec1 = 0; first3 = -1;
    @(negedge clk); rst = 1; pipe_on = 1;
    @(negedge clk); rst = 0;
    for (int t = 0; t < 10; t++) begin
      @(negedge clk); #1;
      if (!pc_we) stalls++;
      if (ifid_idx == 1) dec1++;
      if (ifid_idx == 3 && first3 < 0) first3 = t;
    end
    pipe_on = 0;
  endtask

  initial begin
    int st, d1, f3, base;
    logic [AW-1:0] a, b, d;
    ex_mem_read = 0; ex_load_rt = 0; id_src_a = 0; id_src_b = 0; dec_ctrl = 0;
    repeat (2) @(negedge clk);
    rst = 0;

    // Reset-time idle inputs: no stall, pass-through.
    apply(0, 0, 0, 0, 9'h000, "R3 idle");
    // Directed corners.
    apply(1, 5'd2, 5'd2, 5'd5, C_ALU, "R1 src_a match");
    apply(1, 5'd7, 5'd3, 5'd7, C_ALU, "R2 src_b match");
    apply(1, 5'd9, 5'd9, 5'd9, 9'h1FF, "R1 both match");
    apply(0, 5'd4, 5'd4, 5'd4, 9'h1AB, "R3 non-load match");
    apply(1, 5'd0, 5'd0, 5'd0, 9'h0F0, "R4 zero dst");
    apply(1, 5'd31, 5'd30, 5'd1, 9'h155, "R9 load no match");
    apply(1, 5'd31, 5'd31, 5'd0, 9'h0AA, "R1 top index");

    // Random patterns from a small register set to hit matches often.
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      d = AW'($urandom % 4);
      a = AW'($urandom % 4);
      b = AW'($urandom % 4);
      apply(1'($urandom), d, a, b, CW'($urandom), "R1/R2/R3/R4 random");
    end

    // Pipeline: dependent use right after load.
    load_prog(5'd2, 5'd2);
    run_prog(st, d1, f3);
    chk("R8 stall count", st, 1);
    chk("R8 dependent decode repeats", d1, 2);
    base = f3;
    // Load to r0: no stall.
    load_prog(5'd0, 5'd0);
    run_prog(st, d1, f3);
    chk("R4 pipeline r0 stalls", st, 0);
    chk("R4 pipeline r0 decode", d1, 1);
    chk("R8 fetch delayed one cycle", base, f3 + 1);
    // Independent sequence: no stall.
    load_prog(5'd2, 5'd3);
    run_prog(st, d1, f3);
    chk("R9 independent stalls", st, 0);

    report();
  end
endmodule